// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block tracks the coherence state of one cache line in a snooping multiprocessor that uses writeback caches and invalidation. It holds one of four stable states (Invalid, Shared, Exclusive, Modified). It serves processor reads, writes and replacements. When a request needs the shared bus, it raises a bus command and waits for the bus to report completion. The data array, bus arbitration and memory are outside the block. One copy is instantiated per line, or per tag entry, in each cache.

A read miss places a read on the bus. The final state is not known when the read is issued, so the controller waits in a transient state until the bus reports completion. At that point it samples the wired-OR shared line: Exclusive if no other cache holds the line, Shared otherwise. A later write to an Exclusive line becomes Modified without any bus traffic. For snooped reads and read-for-ownership transactions, the block reports a hit, contributes to the shared line, and flushes the line when it is the data supplier. Among several Shared holders, the supplier is the cache with the lowest ID that reports a hit.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset, line_state is Invalid (code 0), busy is low and bus_cmd is idle (code 0).
- R2: A read to an Invalid line drives bus_cmd=1 (read) in the request cycle with no ack, then holds busy. In the cycle bus_done is high, pr_ack rises and shr_in is sampled: the next state is Shared (code 1) if shr_in is high, Exclusive (code 2) if it is low.
- R3: A read to a Shared, Exclusive or Modified line is acknowledged in the same cycle, with no bus command and no state change.
- R4: A write to an Exclusive line is acknowledged in the same cycle with no bus command, and the state becomes Modified (code 3). A write to a Modified line is acknowledged silently and the state stays Modified.
- R5: A write to a Shared or Invalid line drives bus_cmd=2 (read-for-ownership) and waits. In the cycle bus_done is high, pr_ack rises and the state becomes Modified.
- R6: Evicting a Shared or Exclusive line is acknowledged at once and the line becomes Invalid with no bus command. Evicting a Modified line drives bus_cmd=3 (writeback) and the line becomes Invalid once bus_done is seen. Evicting an Invalid line is acknowledged with no effect.
- R7: A snooped read (snp_valid=1, snp_rdx=0) to a valid line raises snp_hit and shr_out. A Modified or Exclusive line moves to Shared.
- R8: A snooped read-for-ownership (snp_rdx=1) to a valid line raises snp_hit, keeps shr_out low, and invalidates the line.
- R9: On a snoop hit, a Modified or Exclusive line always raises flush. A Shared line raises flush only when no peer_hit bit with an index below MY_ID is set; peer_hit bits at or above MY_ID have no effect.
- R10: A snoop in a stable state takes priority: in that cycle no processor request is acknowledged and no bus command is driven.
- R11: While busy, snoops produce no hit, shared or flush output and leave the pending request unchanged. Outside a pending request, bus_done and shr_in are ignored.
- R12: When several processor requests are raised together, evict wins over write, and write wins over read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pr_rd | input | 1 | Processor read request, held until pr_ack |
| pr_wr | input | 1 | Processor write request, held until pr_ack |
| pr_evict | input | 1 | Replacement request, held until pr_ack |
| pr_ack | output | 1 | Processor request completes this cycle |
| bus_cmd | output | 2 | Bus request: 0 idle, 1 read, 2 read-for-ownership, 3 writeback |
| bus_done | input | 1 | Issued bus transaction completes this cycle |
| shr_in | input | 1 | Wired-OR shared line, valid with bus_done |
| snp_valid | input | 1 | A snooped transaction is on the bus |
| snp_rdx | input | 1 | Snooped type: 0 read, 1 read-for-ownership |
| peer_hit | input | NCACHE | Snoop hit reports of all caches, indexed by cache ID |
| snp_hit | output | 1 | This cache holds the snooped line valid |
| shr_out | output | 1 | Contribution to the wired-OR shared line |
| flush | output | 1 | This cache supplies the line data |
| line_state | output | 2 | Visible state: 0 I, 1 S, 2 E, 3 M (Invalid while busy) |
| busy | output | 1 | A bus transaction of this line is pending |

## Verification
A wrong internal state shows up at the ports in one of two places. It appears on the next processor request, as an ack where a bus command was due or as a wrong command code in the request cycle. It also appears on the next snoop, as a missing or extra hit, shared or flush in that same cycle. line_state exposes the stable state one cycle after each transition, so a wrong next-state choice from the sampled shared line or from a snoop is visible on the following cycle. The sweep starts from every stable state and covers all processor operations, both shared-line values, both snoop types and every peer-hit pattern.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_RD   = 2'd1,
        BC_RDX  = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_t;

    typedef enum logic [2:0] {
        CS_I, CS_S, CS_E, CS_M, CS_RD_WAIT, CS_RDX_WAIT, CS_WB_WAIT
    } ctl_st_t;

    typedef enum logic [1:0] {
        OP_NONE, OP_RD, OP_WR, OP_EV
    } pr_op_t;

    typedef struct packed {
        logic hit;
        logic shared;
        logic flush;
        logic kill;
        logic demote;
    } snp_resp_t;

    function automatic logic is_pending(ctl_st_t s);
        return (s == CS_RD_WAIT) || (s == CS_RDX_WAIT) || (s == CS_WB_WAIT);
    endfunction

    function automatic line_st_t visible_state(ctl_st_t s);
        case (s)
            CS_S:    return LS_S;
            CS_E:    return LS_E;
            CS_M:    return LS_M;
            default: return LS_I;
        endcase
    endfunction

endpackage

// File: rtl/mesi_req_sel.sv
module mesi_req_sel
    import mesi_pkg::*;
(
    input  logic   rd,
    input  logic   wr,
    input  logic   ev,
    output pr_op_t op
);
    always_comb begin
        if (ev)      op = OP_EV;
        else if (wr) op = OP_WR;
        else if (rd) op = OP_RD;
        else         op = OP_NONE;
    end
endmodule

// File: rtl/mesi_supplier_sel.sv
module mesi_supplier_sel #(
    parameter int NCACHE = 4,
    parameter int MY_ID  = 2
) (
    input  logic [NCACHE-1:0] peer_hit,
    output logic              lower_hit
);
    localparam logic [NCACHE-1:0] LOW_MASK = NCACHE'((64'd1 << MY_ID) - 64'd1);

    logic [NCACHE-1:0] lower_bits;

    for (genvar i = 0; i < NCACHE; i++) begin : g_mask
        assign lower_bits[i] = peer_hit[i] & LOW_MASK[i];
    end

    assign lower_hit = |lower_bits;
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_pkg::*;
(
    input  logic      snp_valid,
    input  logic      snp_rdx,
    input  ctl_st_t   st,
    input  logic      lower_hit,
    output snp_resp_t rsp
);
    logic valid_line;
    logic owner;

    assign valid_line = (st == CS_S) || (st == CS_E) || (st == CS_M);
    assign owner      = (st == CS_E) || (st == CS_M);

    always_comb begin
        rsp.hit    = snp_valid & valid_line;
        rsp.shared = rsp.hit & ~snp_rdx;
        rsp.flush  = rsp.hit & (owner | ~lower_hit);
        rsp.kill   = rsp.hit & snp_rdx;
        rsp.demote = rsp.hit & ~snp_rdx & owner;
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int NCACHE = 4,
    parameter int MY_ID  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pr_rd,
    input  logic              pr_wr,
    input  logic              pr_evict,
    output logic              pr_ack,
    output logic [1:0]        bus_cmd,
    input  logic              bus_done,
    input  logic              shr_in,
    input  logic              snp_valid,
    input  logic              snp_rdx,
    input  logic [NCACHE-1:0] peer_hit,
    output logic              snp_hit,
    output logic              shr_out,
    output logic              flush,
    output logic [1:0]        line_state,
    output logic              busy
);
    ctl_st_t   st, st_nxt;
    pr_op_t    op;
    snp_resp_t rsp;
    bus_cmd_t  cmd;
    logic      lower_hit;
    logic      pend;

    mesi_req_sel u_req (
        .rd (pr_rd),
        .wr (pr_wr),
        .ev (pr_evict),
        .op (op)
    );

    mesi_supplier_sel #(.NCACHE(NCACHE), .MY_ID(MY_ID)) u_sup (
        .peer_hit  (peer_hit),
        .lower_hit (lower_hit)
    );

    mesi_snoop_resp u_snp (
        .snp_valid (snp_valid),
        .snp_rdx   (snp_rdx),
        .st        (st),
        .lower_hit (lower_hit),
        .rsp       (rsp)
    );

    assign pend = is_pending(st);

    always_comb begin
        st_nxt = st;
        cmd    = BC_NONE;
        pr_ack = 1'b0;
        if (pend) begin
            if (bus_done) begin
                pr_ack = 1'b1;
                case (st)
                    CS_RD_WAIT:  st_nxt = shr_in ? CS_S : CS_E;
                    CS_RDX_WAIT: st_nxt = CS_M;
                    default:     st_nxt = CS_I;
                endcase
            end
        end else if (snp_valid) begin
            if (rsp.kill)        st_nxt = CS_I;
            else if (rsp.demote) st_nxt = CS_S;
        end else begin
            case (st)
                CS_I: begin
                    case (op)
                        OP_RD: begin cmd = BC_RD;  st_nxt = CS_RD_WAIT;  end
                        OP_WR: begin cmd = BC_RDX; st_nxt = CS_RDX_WAIT; end
                        OP_EV: pr_ack = 1'b1;
                        default: ;
                    endcase
                end
                CS_S: begin
                    case (op)
                        OP_RD: pr_ack = 1'b1;
                        OP_WR: begin cmd = BC_RDX; st_nxt = CS_RDX_WAIT; end
                        OP_EV: begin pr_ack = 1'b1; st_nxt = CS_I; end
                        default: ;
                    endcase
                end
                CS_E: begin
                    case (op)
                        OP_RD: pr_ack = 1'b1;
                        OP_WR: begin pr_ack = 1'b1; st_nxt = CS_M; end
                        OP_EV: begin pr_ack = 1'b1; st_nxt = CS_I; end
                        default: ;
                    endcase
                end
                CS_M: begin
                    case (op)
                        OP_RD, OP_WR: pr_ack = 1'b1;
                        OP_EV: begin cmd = BC_WB; st_nxt = CS_WB_WAIT; end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= CS_I;
        else     st <= st_nxt;
    end

    assign bus_cmd    = cmd;
    assign snp_hit    = rsp.hit;
    assign shr_out    = rsp.shared;
    assign flush      = rsp.flush;
    assign line_state = visible_state(st);
    assign busy       = pend;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       pr_rd,
    input logic       pr_wr,
    input logic       pr_evict,
    input logic       pr_ack,
    input logic [1:0] bus_cmd,
    input logic       snp_valid,
    input logic       snp_rdx,
    input logic       snp_hit,
    input logic       shr_out,
    input logic       flush,
    input logic [1:0] line_state,
    input logic       busy
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (line_state == 2'd0 && !busy));

    assert_issue_goes_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && bus_cmd != 2'd0) |=> busy);

    assert_excl_write_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (line_state == 2'd2 && !busy && pr_wr && !pr_evict && !snp_valid)
        |-> (bus_cmd == 2'd0 && pr_ack));

    assert_excl_write_to_mod_R4: assert property (@(posedge clk) disable iff (rst)
        (line_state == 2'd2 && !busy && pr_wr && !pr_evict && !snp_valid)
        |=> line_state == 2'd3);

    assert_snoop_read_shares_R7: assert property (@(posedge clk) disable iff (rst)
        (snp_hit && !snp_rdx) |-> shr_out ##1 (line_state == 2'd1));

    assert_snoop_rdx_kills_R8: assert property (@(posedge clk) disable iff (rst)
        (snp_hit && snp_rdx) |-> !shr_out ##1 (line_state == 2'd0));

    assert_flush_needs_hit_R9: assert property (@(posedge clk) disable iff (rst)
        flush |-> snp_hit);

    assert_snoop_blocks_proc_R10: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && !busy) |-> (bus_cmd == 2'd0 && !pr_ack));

    assert_pending_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!snp_hit && !flush && !shr_out && bus_cmd == 2'd0 && line_state == 2'd0));

    assert_no_request_no_ack_R12: assert property (@(posedge clk) disable iff (rst)
        (!busy && !pr_rd && !pr_wr && !pr_evict) |-> (!pr_ack && bus_cmd == 2'd0));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pr_rd      (pr_rd),
    .pr_wr      (pr_wr),
    .pr_evict   (pr_evict),
    .pr_ack     (pr_ack),
    .bus_cmd    (bus_cmd),
    .snp_valid  (snp_valid),
    .snp_rdx    (snp_rdx),
    .snp_hit    (snp_hit),
    .shr_out    (shr_out),
    .flush      (flush),
    .line_state (line_state),
    .busy       (busy)
);

// File: tb/sim_mesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_line_ctrl;
    localparam int NC = 4;
    localparam int ID = 2;
    localparam int ST_I = 0, ST_S = 1, ST_E = 2, ST_M = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pr_rd = 0, pr_wr = 0, pr_evict = 0, bus_done = 0, shr_in = 0;
    logic snp_valid = 0, snp_rdx = 0;
    logic [NC-1:0] peer_hit = '0;
    logic pr_ack, snp_hit, shr_out, flush, busy;
    logic [1:0] bus_cmd, line_state;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mesi_line_ctrl #(.NCACHE(NC), .MY_ID(ID)) u0 (
        .clk(clk), .rst(rst), .pr_rd(pr_rd), .pr_wr(pr_wr), .pr_evict(pr_evict),
        .pr_ack(pr_ack), .bus_cmd(bus_cmd), .bus_done(bus_done), .shr_in(shr_in),
        .snp_valid(snp_valid), .snp_rdx(snp_rdx), .peer_hit(peer_hit),
        .snp_hit(snp_hit), .shr_out(shr_out), .flush(flush),
        .line_state(line_state), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // drives a processor request; completes a bus transaction if one is issued
    task automatic proc_op(input bit rd, input bit wr, input bit ev, input bit sh,
                           output int cmd0, output int ack0);
        pr_rd = rd; pr_wr = wr; pr_evict = ev;
        #2;
        cmd0 = int'(bus_cmd);
        ack0 = int'(pr_ack);
        if (!pr_ack) begin
            tick();
            bus_done = 1'b1; shr_in = sh;
            #2;
            chk("R2/R5/R6 ack on bus_done", int'(pr_ack), 1);
        end
        tick();
        pr_rd = 0; pr_wr = 0; pr_evict = 0; bus_done = 0; shr_in = 0;
    endtask

    task automatic goto_state(input int s);
        int c, a;
        proc_op(0, 0, 1, 0, c, a);
        case (s)
            ST_S: proc_op(1, 0, 0, 1, c, a);
            ST_E: proc_op(1, 0, 0, 0, c, a);
            ST_M: proc_op(0, 1, 0, 0, c, a);
            default: ;
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int c, a;
        repeat (3) tick();
        // R1: reset state
        chk("R1 line_state", int'(line_state), ST_I);
        chk("R1 busy", int'(busy), 0);
        chk("R1 bus_cmd", int'(bus_cmd), 0);
        rst = 0;
        tick();

        // R2 R3 R4 R5 R6: every processor op from every stable state
        for (int s = 0; s < 4; s++) begin
            for (int op = 0; op < 3; op++) begin
                for (int sh = 0; sh < 2; sh++) begin
                    int ecmd, est;
                    goto_state(s);
                    chk("R2-setup state", int'(line_state), s);
                    if (op == 0) begin
                        ecmd = (s == ST_I) ? 1 : 0;
                        est  = (s == ST_I) ? (sh ? ST_S : ST_E) : s;
                    end else if (op == 1) begin
                        ecmd = (s == ST_I || s == ST_S) ? 2 : 0;
                        est  = ST_M;
                    end else begin
                        ecmd = (s == ST_M) ? 3 : 0;
                        est  = ST_I;
                    end
                    proc_op(op == 0, op == 1, op == 2, sh[0], c, a);
                    if (op == 0) begin
                        chk("R2/R3 read bus_cmd", c, ecmd);
                        chk("R2/R3 read state", int'(line_state), est);
                    end else if (op == 1) begin
                        chk("R4/R5 write bus_cmd", c, ecmd);
                        chk("R4/R5 write state", int'(line_state), est);
                    end else begin
                        chk("R6 evict bus_cmd", c, ecmd);
                        chk("R6 evict state", int'(line_state), est);
                    end
                    chk("R3/R4/R6 immediate ack", a, (ecmd == 0) ? 1 : 0);
                end
            end
        end

        // R7 R8 R9: snoop sweep over states, types and peer-hit patterns
        for (int s = 0; s < 4; s++) begin
            for (int rx = 0; rx < 2; rx++) begin
                for (int p = 0; p < (1 << NC); p++) begin
                    int hit, eflush, est;
                    goto_state(s);
                    hit    = (s != ST_I);
                    eflush = hit && (s != ST_S || (p & ((1 << ID) - 1)) == 0);
                    est    = hit ? (rx ? ST_I : ST_S) : ST_I;
                    snp_valid = 1; snp_rdx = rx[0]; peer_hit = p[NC-1:0];
                    #2;
                    chk("R7/R8 snp_hit", int'(snp_hit), hit);
                    chk("R7/R8 shr_out", int'(shr_out), hit && !rx);
                    chk("R9 flush", int'(flush), eflush);
                    tick();
                    snp_valid = 0; snp_rdx = 0; peer_hit = '0;
                    chk("R7/R8 state after snoop", int'(line_state), est);
                end
            end
        end

        // R10: snoop and write in the same cycle on Exclusive
        goto_state(ST_E);
        pr_wr = 1; snp_valid = 1; snp_rdx = 0;
        #2;
        chk("R10 no ack under snoop", int'(pr_ack), 0);
        chk("R10 no bus_cmd under snoop", int'(bus_cmd), 0);
        tick();
        snp_valid = 0;
        chk("R10 snoop applied", int'(line_state), ST_S);
        #2;
        chk("R10 retried write needs rdx", int'(bus_cmd), 2);
        tick();
        bus_done = 1;
        tick();
        pr_wr = 0; bus_done = 0;
        chk("R10 write completes", int'(line_state), ST_M);

        // R11: snoop during pending read is ignored
        goto_state(ST_I);
        pr_rd = 1;
        tick();
        snp_valid = 1; snp_rdx = 1; peer_hit = '0;
        #2;
        chk("R11 busy", int'(busy), 1);
        chk("R11 no snp_hit while busy", int'(snp_hit), 0);
        chk("R11 no flush while busy", int'(flush), 0);
        tick();
        snp_valid = 0; bus_done = 1; shr_in = 0;
        tick();
        pr_rd = 0; bus_done = 0;
        chk("R11 pending read lands Exclusive", int'(line_state), ST_E);

        // R11: bus_done and shr_in outside pending are ignored
        bus_done = 1; shr_in = 1;
        tick();
        bus_done = 0; shr_in = 0;
        chk("R11 stray bus_done ignored", int'(line_state), ST_E);

        // R12: write beats read, evict beats write
        proc_op(1, 1, 0, 0, c, a);
        chk("R12 write over read", int'(line_state), ST_M);
        proc_op(0, 1, 1, 0, c, a);
        chk("R12 evict over write cmd", c, 3);
        chk("R12 evict over write state", int'(line_state), ST_I);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule